// File: doc/BRIEF.md
# Memory protection region checker

This block judges every memory access against eight programmable protection regions. Each region has a base address and an attribute word. A lookup presents an address, a privilege level, an access kind and a flag that marks a hard-fault or non-maskable-interrupt handler. In the same cycle the block answers with grant or fault and names the region that decided the outcome. A global control word switches checking on, lets privileged accesses fall back to the default memory map, and decides whether handler code is checked at all.

Region sizes are powers of two, written as a log value. Every region is split into eight equal sub-regions, and each sub-region can be masked out so that a lower-numbered region shows through. The first fault after a clear stores its address and access kind in a status register, which holds them until the clear input is pulsed.

Top module: `mpu_guard`

## Requirements
- R1: After reset all regions are disabled, the control word is zero and the fault status is empty, so a requested access is granted and `flt_valid` is 0.
- R2: While control bit 0 (checking enable) is clear, every requested access is granted, `hit` is 0 and the fault status does not capture.
- R3: Attribute bits [5:1] hold N. The region spans 2^(N+1) bytes, and address bits N down to 0 are ignored in the comparison with the base, so a misaligned base is treated as aligned. A region with N below 4 never matches.
- R4: Attribute bit 0 enables a region. Config operation 2 rewrites only that bit from `cfg_wdata[0]`, and the rest of the configuration is kept.
- R5: Permission code in attribute bits [26:24]: 0 none; 1 privileged read/write only; 2 privileged read/write, user read; 3 all read/write; 5 privileged read only; 6 read only for both. Codes 4 and 7 grant nothing.
- R6: Access kind 0 is read, 1 is write, 2 or 3 is instruction fetch. A fetch needs read permission and faults when attribute bit 28 (execute-never) is set.
- R7: Attribute bit 8+k masks sub-region k, where k is address bits [N:N-2]. A masked sub-region does not match. The mask applies only when N is 7 or more (256 bytes and up).
- R8: When several enabled regions match, the highest-numbered one decides, and `hit_idx` reports it.
- R9: An access that matches no region is granted when it is privileged and control bit 1 (default-map fallback) is set. Otherwise it faults.
- R10: With `req_in_handler` high and control bit 2 (check handlers) clear, the checks are bypassed and the access is granted with `hit` 0. With bit 2 set, handler accesses are checked normally.
- R11: A fault with an empty status stores the address and access kind and sets `flt_valid`. Later faults leave the stored values untouched. `flt_clr` empties the status on the next edge, and it takes priority over a fault in the same cycle.
- R12: Config operation 0 writes the base and operation 1 writes the attribute word of region `cfg_idx`. `ctl_we` loads control bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_op | input | 2 | 0 base, 1 attribute, 2 enable bit only |
| cfg_idx | input | 3 | Region number written |
| cfg_wdata | input | 32 | Configuration data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | bit0 enable, bit1 default-map fallback, bit2 check handlers |
| flt_clr | input | 1 | Empties the fault status |
| req | input | 1 | Lookup request |
| req_addr | input | 32 | Access address |
| req_priv | input | 1 | 1 = privileged access |
| req_acc | input | 2 | Access kind (see R6) |
| req_in_handler | input | 1 | Access made from a fault or NMI handler |
| allow | output | 1 | Access granted |
| fault | output | 1 | Access refused |
| hit | output | 1 | An enabled region decided the access |
| hit_idx | output | 3 | Number of the deciding region |
| flt_valid | output | 1 | Fault status holds a record |
| flt_addr | output | 32 | Address of the recorded fault |
| flt_acc | output | 2 | Access kind of the recorded fault |

## Verification
The bench aims at the size arithmetic: an address one byte past a 4 KB region, a base with junk in its low bits, and an encoded size below 32 bytes. Wrong masking shows up there as a false hit or a missed hit. Sub-region holes are probed in a 1 KB region and in a 128 B region where the mask must be ignored. Overlaps between a read-only region and a higher-numbered no-access region expose a reversed priority, and the reserved codes 4 and 7 catch a permission table that leaks grants. The fallback paths are covered as well: privileged versus user on a miss, handler bypass with and without handler checking, and the disabled module. A status register that keeps overwriting, or that ignores its clear, shows up in the readback after two successive faults.

// File: rtl/mpu_guard_pkg.sv
// Shared field positions, access kinds and the permission decode for the
// region checker. Assumes 32-bit addresses and attribute words.
package mpu_guard_pkg;

    localparam int ADDR_W   = 32;
    localparam int ATTR_W   = 32;
    localparam int SZ_LO    = 1;
    localparam int SZ_HI    = 5;
    localparam int SRD_LO   = 8;
    localparam int AP_LO    = 24;
    localparam int AP_HI    = 26;
    localparam int XN_BIT   = 28;
    localparam int MIN_SZ   = 4;
    localparam int SRD_MIN  = 7;

    localparam int CTL_EN   = 0;
    localparam int CTL_PDEF = 1;
    localparam int CTL_HFCK = 2;

    typedef enum logic [1:0] {
        OP_BASE = 2'd0,
        OP_ATTR = 2'd1,
        OP_ENAB = 2'd2,
        OP_NONE = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_FX  = 2'd2,
        ACC_FX2 = 2'd3
    } acc_e;

    // Decides whether one access kind is permitted by a permission code.
    function automatic logic perm_ok(input logic [2:0] ap, input logic xn,
                                     input logic priv, input logic [1:0] acc);
        logic [3:0] g;   // {priv rd, priv wr, user rd, user wr}
        logic       rd;
        logic       wr;
        case (ap)
            3'd1:    g = 4'b1100;
            3'd2:    g = 4'b1110;
            3'd3:    g = 4'b1111;
            3'd5:    g = 4'b1000;
            3'd6:    g = 4'b1010;
            default: g = 4'b0000;
        endcase
        rd = priv ? g[3] : g[1];
        wr = priv ? g[2] : g[0];
        if (acc[1])
            return rd & ~xn;
        else if (acc == ACC_WR)
            return wr;
        else
            return rd;
    endfunction

endpackage

// File: rtl/mpu_rgn_match.sv
// Address matcher for one protection region. Assumes the attribute word uses
// the package field positions; a size code below MIN_SZ never matches, and
// base bits inside the region span are ignored.
module mpu_rgn_match
    import mpu_guard_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ATTR_W-1:0] attr,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [4:0]        sz;
    logic [ADDR_W-1:0] cmp_mask;
    logic [2:0]        sub;
    logic              sub_off;

    assign sz = attr[SZ_HI:SZ_LO];

    // Builds the mask of address bits above the region span.
    always_comb begin
        for (int b = 0; b < ADDR_W; b++)
            cmp_mask[b] = (b > int'(sz));
    end

    // Picks the sub-region index and checks its mask bit.
    always_comb begin
        sub     = 3'(addr >> (sz - 5'd2));
        sub_off = (sz >= 5'(SRD_MIN)) && attr[SRD_LO + int'(sub)];
    end

    // Combines enable, size validity, base compare and sub-region mask.
    assign hit = attr[0] && (sz >= 5'(MIN_SZ)) &&
                 (((addr ^ base) & cmp_mask) == '0) && !sub_off;

endmodule

// File: rtl/mpu_rgn_pick.sv
// Priority selector: the highest-numbered matching region wins.
// Assumes NUM regions, NUM at least 2.
module mpu_rgn_pick #(
    parameter int NUM   = 8,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scans upward so that a later match overrides an earlier one.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mpu_guard.sv
// Memory protection region checker. Holds the region and control registers,
// looks up each access combinationally and records the first fault. Assumes
// lookups are qualified by req; the allow and fault outputs are 0 without it.
module mpu_guard
    import mpu_guard_pkg::*;
#(
    parameter int NUM_RGN = 8,
    localparam int IDX_W  = $clog2(NUM_RGN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_op,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ATTR_W-1:0] cfg_wdata,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_wdata,
    input  logic              flt_clr,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_priv,
    input  logic [1:0]        req_acc,
    input  logic              req_in_handler,
    output logic              allow,
    output logic              fault,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_acc
);
    logic [ADDR_W-1:0] base_q [NUM_RGN];
    logic [ATTR_W-1:0] attr_q [NUM_RGN];
    logic [2:0]        ctl_q;
    logic [NUM_RGN-1:0] rgn_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic [ATTR_W-1:0]  sel_attr;
    logic               sel_xn;
    logic               bypass;
    logic               ok;

    // Region register file, written one field at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                base_q[i] <= '0;
                attr_q[i] <= '0;
            end
        end else if (cfg_we) begin
            case (cfg_op)
                OP_BASE: base_q[cfg_idx]    <= cfg_wdata;
                OP_ATTR: attr_q[cfg_idx]    <= cfg_wdata;
                OP_ENAB: attr_q[cfg_idx][0] <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // Global control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        mpu_rgn_match u_match (
            .base (base_q[g]),
            .attr (attr_q[g]),
            .addr (req_addr),
            .hit  (rgn_hit[g])
        );
    end

    mpu_rgn_pick #(.NUM(NUM_RGN), .IDX_W(IDX_W)) u_pick (
        .hits (rgn_hit),
        .any  (any_hit),
        .idx  (pick_idx)
    );

    assign sel_attr = attr_q[pick_idx];
    assign sel_xn   = sel_attr[XN_BIT];

    // Decides grant or fault from bypass, region match and fallback.
    always_comb begin
        bypass = !ctl_q[CTL_EN] || (req_in_handler && !ctl_q[CTL_HFCK]);
        if (bypass)
            ok = 1'b1;
        else if (any_hit)
            ok = perm_ok(sel_attr[AP_HI:AP_LO], sel_xn, req_priv, req_acc);
        else
            ok = req_priv && ctl_q[CTL_PDEF];
    end

    assign allow   = req && ok;
    assign fault   = req && !ok;
    assign hit     = !bypass && any_hit;
    assign hit_idx = hit ? pick_idx : '0;

    // Fault status: first fault is kept until cleared; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid <= 1'b0;
            flt_addr  <= '0;
            flt_acc   <= '0;
        end else if (flt_clr) begin
            flt_valid <= 1'b0;
        end else if (fault && !flt_valid) begin
            flt_valid <= 1'b1;
            flt_addr  <= req_addr;
            flt_acc   <= req_acc;
        end
    end

endmodule

// File: rtl/mpu_guard_chk.sv
// Assertion checker for the region checker, attached by bind.
module mpu_guard_chk
    import mpu_guard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_priv,
    input logic [1:0]        req_acc,
    input logic              req_in_handler,
    input logic [2:0]        ctl_q,
    input logic              sel_xn,
    input logic              allow,
    input logic              fault,
    input logic              hit,
    input logic              flt_clr,
    input logic              flt_valid,
    input logic [ADDR_W-1:0] flt_addr
);
    p_off_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ctl_q[CTL_EN] |-> allow && !fault && !hit);

    p_xn_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req && hit && req_acc[1] && sel_xn |-> fault);

    p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req && !hit && req_priv && ctl_q[CTL_PDEF] |-> allow);

    p_miss_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req && ctl_q[CTL_EN] && !hit && !(req_priv && ctl_q[CTL_PDEF])
            && !(req_in_handler && !ctl_q[CTL_HFCK]) |-> fault);

    p_handler_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req && req_in_handler && !ctl_q[CTL_HFCK] |-> allow && !hit);

    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req && fault && !flt_valid && !flt_clr |=>
            flt_valid && (flt_addr == $past(req_addr)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !flt_clr |=> flt_valid && $stable(flt_addr));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> !flt_valid);

endmodule

bind mpu_guard mpu_guard_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .req_addr       (req_addr),
    .req_priv       (req_priv),
    .req_acc        (req_acc),
    .req_in_handler (req_in_handler),
    .ctl_q          (ctl_q),
    .sel_xn         (sel_xn),
    .allow          (allow),
    .fault          (fault),
    .hit            (hit),
    .flt_clr        (flt_clr),
    .flt_valid      (flt_valid),
    .flt_addr       (flt_addr)
);

// File: tb/mpu_guard_tb.sv
`timescale 1ns/1ps
module mpu_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = 3'd0;
    logic        flt_clr = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        req_priv = 1'b0;
    logic [1:0]  req_acc = 2'd0;
    logic        req_in_handler = 1'b0;
    logic        allow, fault, hit, flt_valid;
    logic [2:0]  hit_idx;
    logic [31:0] flt_addr;
    logic [1:0]  flt_acc;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  e_allow;
        logic  e_hit;
        int    e_idx;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event ev_look;

    always #2 clk = ~clk;

    mpu_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .flt_clr(flt_clr), .req(req),
        .req_addr(req_addr), .req_priv(req_priv), .req_acc(req_acc),
        .req_in_handler(req_in_handler), .allow(allow), .fault(fault),
        .hit(hit), .hit_idx(hit_idx), .flt_valid(flt_valid),
        .flt_addr(flt_addr), .flt_acc(flt_acc)
    );

    // Monitor: pops each expected lookup result and compares.
    initial begin
        forever begin
            exp_t it;
            @(ev_look);
            #1;
            it = exp_q.pop_front();
            n_vec++;
            if (allow !== it.e_allow || fault !== !it.e_allow || hit !== it.e_hit ||
                (it.e_hit && hit_idx !== 3'(it.e_idx))) begin
                n_bad++;
                $display("FAIL %s: allow/fault/hit/idx=%b/%b/%b/%0d expected %b/%b/%b/%0d",
                         it.tag, allow, fault, hit, hit_idx,
                         it.e_allow, !it.e_allow, it.e_hit, it.e_idx);
            end
        end
    end

    task automatic look(input logic priv, input logic [1:0] acc,
                        input logic [31:0] a, input logic e_allow,
                        input logic e_hit, input int e_idx, input string tag);
        exp_t it;
        @(negedge clk);
        req = 1'b1; req_priv = priv; req_acc = acc; req_addr = a;
        it.e_allow = e_allow; it.e_hit = e_hit; it.e_idx = e_idx; it.tag = tag;
        exp_q.push_back(it);
        -> ev_look;
    endtask

    task automatic cfg(input logic [1:0] op, input logic [2:0] idx,
                       input logic [31:0] d);
        @(negedge clk);
        req = 1'b0; cfg_we = 1'b1; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rgn(input logic [2:0] idx, input logic [31:0] b,
                       input logic [31:0] at);
        cfg(2'd0, idx, b);
        cfg(2'd1, idx, at);
    endtask

    task automatic ctl(input logic [2:0] v);
        @(negedge clk);
        req = 1'b0; ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clear_flt();
        @(negedge clk);
        req = 1'b0; flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
    endtask

    task automatic chk_stat(input logic v, input logic [31:0] a,
                            input logic [1:0] k, input string tag);
        @(negedge clk);
        req = 1'b0;
        #1;
        n_vec++;
        if (flt_valid !== v || (v && (flt_addr !== a || flt_acc !== k))) begin
            n_bad++;
            $display("FAIL %s: status v/addr/acc=%b/%h/%0d expected %b/%h/%0d",
                     tag, flt_valid, flt_addr, flt_acc, v, a, k);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver: the stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        look(0, 2'd1, 32'h0, 1, 0, 0, "R1 reset grants");
        chk_stat(0, 0, 0, "R1 reset status empty");

        ctl(3'b001);
        look(1, 2'd0, 32'h0000_1000, 0, 0, 0, "R9 miss without fallback");
        chk_stat(1, 32'h0000_1000, 2'd0, "R11 first fault captured");
        look(0, 2'd1, 32'h0000_2000, 0, 0, 0, "R9 user miss");
        chk_stat(1, 32'h0000_1000, 2'd0, "R11 later fault ignored");
        clear_flt();
        chk_stat(0, 0, 0, "R11 clear empties status");

        ctl(3'b011);
        look(1, 2'd0, 32'h0000_2000, 1, 0, 0, "R9 privileged fallback");
        look(0, 2'd0, 32'h0000_2000, 0, 0, 0, "R9 user miss faults");

        rgn(3'd2, 32'h2000_0ABC, 32'h0600_0017);
        look(0, 2'd0, 32'h2000_0FFC, 1, 1, 2, "R3 R12 top of 4KB, unaligned base");
        look(0, 2'd1, 32'h2000_0FFC, 0, 1, 2, "R5 read-only write");
        look(0, 2'd0, 32'h2000_1000, 0, 0, 0, "R3 one past end");
        look(1, 2'd0, 32'h2000_1000, 1, 0, 0, "R3 R9 past end privileged");
        look(0, 2'd2, 32'h2000_0010, 1, 1, 2, "R6 fetch with read permission");

        rgn(3'd3, 32'h3000_0000, 32'h1300_0013);
        look(1, 2'd2, 32'h3000_0010, 0, 1, 3, "R6 fetch from execute-never");
        look(1, 2'd3, 32'h3000_0010, 0, 1, 3, "R6 fetch code 3");
        look(1, 2'd0, 32'h3000_0010, 1, 1, 3, "R6 read execute-never ok");

        rgn(3'd5, 32'h5000_0000, 32'h0300_0413);
        look(0, 2'd0, 32'h5000_0100, 0, 0, 0, "R7 masked sub-region 2");
        look(0, 2'd0, 32'h5000_0080, 1, 1, 5, "R7 open sub-region 1");
        look(0, 2'd0, 32'h5000_03FF, 1, 1, 5, "R7 open sub-region 7");

        rgn(3'd6, 32'h6000_0000, 32'h0300_FF0D);
        look(0, 2'd0, 32'h6000_0040, 1, 1, 6, "R7 mask ignored below 256B");

        rgn(3'd4, 32'h4000_0000, 32'h0300_0007);
        look(0, 2'd0, 32'h4000_0000, 0, 0, 0, "R3 size code 3 invalid");
        look(1, 2'd0, 32'h4000_0000, 1, 0, 0, "R3 invalid size privileged");

        rgn(3'd7, 32'h2000_0000, 32'h0000_0013);
        look(0, 2'd0, 32'h2000_0010, 0, 1, 7, "R8 R5 higher region no access");
        look(1, 2'd0, 32'h2000_0010, 0, 1, 7, "R5 code 0 privileged");
        look(0, 2'd0, 32'h2000_0800, 1, 1, 2, "R8 outside upper region");
        cfg(2'd1, 3'd7, 32'h0400_0013);
        look(1, 2'd0, 32'h2000_0010, 0, 1, 7, "R5 reserved code 4");
        cfg(2'd1, 3'd7, 32'h0700_0013);
        look(1, 2'd0, 32'h2000_0010, 0, 1, 7, "R5 reserved code 7");
        cfg(2'd1, 3'd7, 32'h0500_0013);
        look(1, 2'd1, 32'h2000_0010, 0, 1, 7, "R5 code 5 privileged write");
        look(1, 2'd0, 32'h2000_0010, 1, 1, 7, "R5 code 5 privileged read");
        cfg(2'd1, 3'd7, 32'h0100_0013);
        look(1, 2'd1, 32'h2000_0010, 1, 1, 7, "R5 code 1 privileged write");
        look(0, 2'd0, 32'h2000_0010, 0, 1, 7, "R5 code 1 user read");

        cfg(2'd2, 3'd7, 32'h0);
        look(0, 2'd0, 32'h2000_0010, 1, 1, 2, "R4 disabled region skipped");
        cfg(2'd2, 3'd7, 32'h1);
        look(0, 2'd0, 32'h2000_0010, 0, 1, 7, "R4 re-enabled keeps config");

        @(negedge clk); req_in_handler = 1'b1;
        look(0, 2'd0, 32'h2000_0010, 1, 0, 0, "R10 handler bypass");
        ctl(3'b111);
        look(0, 2'd0, 32'h2000_0010, 0, 1, 7, "R10 handler checked");
        @(negedge clk); req_in_handler = 1'b0;

        clear_flt();
        ctl(3'b000);
        look(0, 2'd1, 32'h2000_0010, 1, 0, 0, "R2 disabled grants");
        chk_stat(0, 0, 0, "R2 no capture while disabled");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule